// File: doc/BRIEF.md
# Five-Stage Forwarding Integer Pipeline

This block is a small in-order integer pipeline with five stages: fetch, decode, execute, memory access and writeback. Pipeline registers separate each stage from the next. It executes register-to-register add, subtract, AND and OR, plus a word load and a word store. A new instruction enters every clock, and the pipeline never stalls. The block contains its own instruction memory and data memory. Both memories are written through load ports while the core is held in reset, and the data memory can be read back through a separate read port.

Operand hazards between ALU instructions are removed in two ways. First, the register file hands a writeback value straight to a same-cycle decode read. Second, the execute stage takes its operands from the two younger pipeline registers when they hold a newer value for the same register. As a result, a chain of dependent ALU instructions runs back to back. A consumer placed directly after a load is not protected, and the program must avoid it. Every register write in writeback is reported on a trace port so that a reference model can follow the core.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, every pipeline register holds a bubble and the fetch address is 0. After release, no write appears on the trace port during the first three cycles.
- R2: The instruction at fetch address k reports its register write on the trace port in cycle k+4 after reset release, with no stall cycles.
- R3: Instruction encoding:
  - Opcode in bits [31:26]: 0 = no-op, 1 = add, 2 = subtract, 3 = AND, 4 = OR, 5 = load, 6 = store.
  - Source A in bits [25:21], source B in bits [20:16], ALU destination in bits [15:11].
  - A sign-extended 16-bit offset in bits [15:0].
  - ALU results are 32 bits, modulo 2^32.
- R4: An ALU instruction that reads the destination of the instruction directly before it receives the new value, taken from the execute/memory register.
- R5: An ALU instruction that reads the destination of the instruction two slots earlier receives that value, taken from the memory/writeback register.
- R6: When both older in-flight instructions write the register being read, the younger of the two supplies the operand.
- R7: A register written in writeback is seen by a decode read of that register in the same cycle. A consumer three slots after its producer therefore gets the new value.
- R8: Register 0 always reads as zero. A write to it changes nothing and is not reported on the trace port.
- R9: Memory instructions use the word index (source A + offset) modulo the data memory depth.
  - A load writes the word at that index into register source B.
  - A store writes register source B to that index.
  - The store data is itself forwarded like an ALU operand.
- R10: Stores and no-ops report no write on the trace port.
- R11: With registers holding their index plus 100, the following sequence leaves -2 in register 2: subtract r2=r1-r3, AND r12=r2&r5, OR r13=r6|r2, add r14=r2+r2, store r15 at r2+100. The four later instructions all use -2 as r2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_we | input | 1 | Write strobe for the instruction memory |
| prog_addr | input | IMEM_AW | Instruction memory word index |
| prog_data | input | 32 | Instruction word to store |
| dmem_ld_we | input | 1 | Write strobe for the data memory load port (has priority over stores) |
| dmem_ld_addr | input | DMEM_AW | Data memory word index for the load port |
| dmem_ld_data | input | DW | Data word to store |
| dmem_peek_addr | input | DMEM_AW | Data memory read-back index |
| dmem_peek_data | output | DW | Data memory word at the read-back index |
| wb_valid | output | 1 | A register write happens in writeback this cycle |
| wb_idx | output | REG_AW | Register index being written |
| wb_data | output | DW | Value being written |

## Verification
Two functions can act on the same register in the same cycle. In execute, both the execute/memory and memory/writeback registers can hit the same source, and only the younger one may win. In decode, a writeback write can coincide with a read of the same register. The random programs draw every register field from only eight registers, register 0 included, so both collisions happen many times per run. A directed pair of back-to-back writes to one register, followed by a reader, provokes the double hit on purpose. Each retired write is judged by its index, value and retirement cycle against a sequential reference model in the bench, and the data memory is compared word by word after every run.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam logic [5:0] OP_NOP   = 6'd0;
  localparam logic [5:0] OP_ADD   = 6'd1;
  localparam logic [5:0] OP_SUB   = 6'd2;
  localparam logic [5:0] OP_AND   = 6'd3;
  localparam logic [5:0] OP_OR    = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd5;
  localparam logic [5:0] OP_STORE = 6'd6;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    FWD_RF = 2'd0,
    FWD_MW = 2'd1,
    FWD_EM = 2'd2
  } fwd_sel_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    mem_re;
    logic    mem_we;
    logic    b_imm;
    alu_fn_e fn;
  } ctrl_t;

  function automatic ctrl_t decode_op(logic [5:0] op);
    ctrl_t c;
    c = '0;
    case (op)
      OP_ADD:   begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.fn = ALU_ADD; end
      OP_SUB:   begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.fn = ALU_SUB; end
      OP_AND:   begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.fn = ALU_AND; end
      OP_OR:    begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.fn = ALU_OR;  end
      OP_LOAD:  begin c.reg_we = 1'b1; c.mem_re = 1'b1; c.b_imm = 1'b1; c.fn = ALU_ADD; end
      OP_STORE: begin c.mem_we = 1'b1; c.b_imm = 1'b1; c.fn = ALU_ADD; end
      default:  c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rs_a,
  input  logic [AW-1:0] rs_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] mem_q [NREG];
  logic [DW-1:0] mem_d [NREG];
  logic [AW-1:0] rs   [2];
  logic [DW-1:0] rd   [2];
  logic          wr_en;

  assign wr_en = we && (wa != '0);
  assign rs[0] = rs_a;
  assign rs[1] = rs_b;
  assign rd_a  = rd[0];
  assign rd_b  = rd[1];

  always_comb begin
    for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
    if (wr_en) mem_d[wa] = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
    end
  end

  // read ports: zero register, then same-cycle write-through, then storage
  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (rs[p] == '0)                rd[p] = '0;
      else if (wr_en && wa == rs[p])  rd[p] = wd;
      else                            rd[p] = mem_q[rs[p]];
    end
  end

  // R7
  rf_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> mem_q[$past(wa)] == $past(wd));

  // R7
  rf_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0 && rs_a == wa) |-> rd_a == wd);

endmodule

// File: rtl/pipe5_fwd.sv
module pipe5_fwd
  import pipe5_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          em_we,
  input  logic [AW-1:0] em_dst,
  input  logic          mw_we,
  input  logic [AW-1:0] mw_dst,
  output fwd_sel_e      sel_a,
  output fwd_sel_e      sel_b
);
  logic [AW-1:0] src [2];
  fwd_sel_e      sel [2];

  assign src[0] = src_a;
  assign src[1] = src_b;
  assign sel_a  = sel[0];
  assign sel_b  = sel[1];

  for (genvar p = 0; p < 2; p++) begin : g_op
    logic hit_em;
    logic hit_mw;
    always_comb begin
      hit_em = em_we && (em_dst != '0) && (em_dst == src[p]);
      hit_mw = mw_we && (mw_dst != '0) && (mw_dst == src[p]);
      if (hit_em)      sel[p] = FWD_EM;
      else if (hit_mw) sel[p] = FWD_MW;
      else             sel[p] = FWD_RF;
    end
  end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_fn_e       fn,
  output logic [DW-1:0] y
);
  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IMEM_AW = 7,
  parameter int DMEM_AW = 6,
  parameter int REG_AW  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [31:0]        prog_data,
  input  logic               dmem_ld_we,
  input  logic [DMEM_AW-1:0] dmem_ld_addr,
  input  logic [DW-1:0]      dmem_ld_data,
  input  logic [DMEM_AW-1:0] dmem_peek_addr,
  output logic [DW-1:0]      dmem_peek_data,
  output logic               wb_valid,
  output logic [REG_AW-1:0]  wb_idx,
  output logic [DW-1:0]      wb_data
);
  localparam int IW     = 32;
  localparam int IMM_W  = 16;
  localparam int OP_LSB = 26;
  localparam int RA_LSB = 21;
  localparam int RB_LSB = 16;
  localparam int RD_LSB = 11;
  localparam int IMEM_D = 1 << IMEM_AW;
  localparam int DMEM_D = 1 << DMEM_AW;

  typedef struct packed {
    ctrl_t             c;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [REG_AW-1:0] rd;
    logic [DW-1:0]     va;
    logic [DW-1:0]     vb;
    logic [DW-1:0]     imm;
  } idex_t;

  typedef struct packed {
    logic              reg_we;
    logic              mem_re;
    logic              mem_we;
    logic [REG_AW-1:0] dst;
    logic [DW-1:0]     y;
    logic [DW-1:0]     sd;
  } exmem_t;

  typedef struct packed {
    logic              reg_we;
    logic [REG_AW-1:0] dst;
    logic [DW-1:0]     wd;
  } memwb_t;

  logic [IW-1:0] imem_q [IMEM_D];
  logic [DW-1:0] dmem_q [DMEM_D];

  logic [IMEM_AW-1:0] pc_q, pc_d;
  logic [IW-1:0]      ifid_q, ifid_d;
  idex_t              idex_q, idex_d;
  exmem_t             exmem_q, exmem_d;
  memwb_t             memwb_q, memwb_d;

  // ---------------- fetch ----------------
  always_comb begin
    pc_d   = pc_q + 1'b1;
    ifid_d = imem_q[pc_q];
  end

  always_ff @(posedge clk) begin
    if (prog_we) imem_q[prog_addr] <= prog_data;
  end

  // ---------------- decode ----------------
  logic [5:0]        id_op;
  logic [REG_AW-1:0] id_ra, id_rb, id_rd;
  logic [DW-1:0]     id_va, id_vb;

  assign id_op = ifid_q[IW-1:OP_LSB];
  assign id_ra = ifid_q[RA_LSB +: REG_AW];
  assign id_rb = ifid_q[RB_LSB +: REG_AW];
  assign id_rd = ifid_q[RD_LSB +: REG_AW];

  pipe5_regfile #(.DW(DW), .AW(REG_AW)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .rs_a (id_ra),
    .rs_b (id_rb),
    .rd_a (id_va),
    .rd_b (id_vb),
    .we   (memwb_q.reg_we),
    .wa   (memwb_q.dst),
    .wd   (memwb_q.wd)
  );

  always_comb begin
    idex_d.c   = decode_op(id_op);
    idex_d.ra  = id_ra;
    idex_d.rb  = id_rb;
    idex_d.rd  = id_rd;
    idex_d.va  = id_va;
    idex_d.vb  = id_vb;
    idex_d.imm = {{(DW-IMM_W){ifid_q[IMM_W-1]}}, ifid_q[IMM_W-1:0]};
  end

  // ---------------- execute ----------------
  fwd_sel_e      sel_a, sel_b;
  logic [DW-1:0] ex_a, ex_b, ex_alu_b, ex_y;

  pipe5_fwd #(.AW(REG_AW)) u_fwd (
    .src_a (idex_q.ra),
    .src_b (idex_q.rb),
    .em_we (exmem_q.reg_we),
    .em_dst(exmem_q.dst),
    .mw_we (memwb_q.reg_we),
    .mw_dst(memwb_q.dst),
    .sel_a (sel_a),
    .sel_b (sel_b)
  );

  always_comb begin
    case (sel_a)
      FWD_EM:  ex_a = exmem_q.y;
      FWD_MW:  ex_a = memwb_q.wd;
      default: ex_a = idex_q.va;
    endcase
    case (sel_b)
      FWD_EM:  ex_b = exmem_q.y;
      FWD_MW:  ex_b = memwb_q.wd;
      default: ex_b = idex_q.vb;
    endcase
    ex_alu_b = idex_q.c.b_imm ? idex_q.imm : ex_b;
  end

  pipe5_alu #(.DW(DW)) u_alu (
    .a (ex_a),
    .b (ex_alu_b),
    .fn(idex_q.c.fn),
    .y (ex_y)
  );

  always_comb begin
    exmem_d.reg_we = idex_q.c.reg_we;
    exmem_d.mem_re = idex_q.c.mem_re;
    exmem_d.mem_we = idex_q.c.mem_we;
    exmem_d.dst    = idex_q.c.dst_is_rd ? idex_q.rd : idex_q.rb;
    exmem_d.y      = ex_y;
    exmem_d.sd     = ex_b;
  end

  // ---------------- memory ----------------
  logic [DMEM_AW-1:0] dm_idx;
  logic [DW-1:0]      dm_rd;

  assign dm_idx         = exmem_q.y[DMEM_AW-1:0];
  assign dm_rd          = dmem_q[dm_idx];
  assign dmem_peek_data = dmem_q[dmem_peek_addr];

  always_ff @(posedge clk) begin
    if (dmem_ld_we)          dmem_q[dmem_ld_addr] <= dmem_ld_data;
    else if (exmem_q.mem_we) dmem_q[dm_idx]       <= exmem_q.sd;
  end

  always_comb begin
    memwb_d.reg_we = exmem_q.reg_we;
    memwb_d.dst    = exmem_q.dst;
    memwb_d.wd     = exmem_q.mem_re ? dm_rd : exmem_q.y;
  end

  // ---------------- writeback trace ----------------
  assign wb_valid = memwb_q.reg_we && (memwb_q.dst != '0);
  assign wb_idx   = memwb_q.dst;
  assign wb_data  = memwb_q.wd;

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q    <= pc_d;
      ifid_q  <= ifid_d;
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  // R2
  adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_q.reg_we == $past(idex_q.c.reg_we));

  // R6
  fwd_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_q.reg_we && exmem_q.dst != '0 && exmem_q.dst == idex_q.ra) |-> sel_a == FWD_EM);

  // R3
  alu_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_q.c.fn == ALU_SUB && !idex_q.c.b_imm) |-> (ex_y + ex_b) == ex_a);

  // R9
  st_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_q.mem_we && !dmem_ld_we) |=> dmem_q[$past(dm_idx)] == $past(exmem_q.sd));

endmodule

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;
  localparam int DW  = 32;
  localparam int IAW = 7;
  localparam int DAW = 6;
  localparam int RAW = 5;
  localparam int ID  = 1 << IAW;
  localparam int DD  = 1 << DAW;
  localparam int MAXEV = 256;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           prog_we;
  logic [IAW-1:0] prog_addr;
  logic [31:0]    prog_data;
  logic           dmem_ld_we;
  logic [DAW-1:0] dmem_ld_addr;
  logic [DW-1:0]  dmem_ld_data;
  logic [DAW-1:0] dmem_peek_addr;
  logic [DW-1:0]  dmem_peek_data;
  logic           wb_valid;
  logic [RAW-1:0] wb_idx;
  logic [DW-1:0]  wb_data;

  pipe5_core #(.DW(DW), .IMEM_AW(IAW), .DMEM_AW(DAW), .REG_AW(RAW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .dmem_peek_addr(dmem_peek_addr), .dmem_peek_data(dmem_peek_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] prog  [ID];
  int          plen;
  logic [31:0] dinit [DD];
  logic [31:0] m_dm  [DD];

  int          exp_n;
  logic [4:0]  exp_idx [MAXEV];
  logic [31:0] exp_dat [MAXEV];
  int          exp_cyc [MAXEV];
  int          obs_n;
  logic [4:0]  obs_idx [MAXEV];
  logic [31:0] obs_dat [MAXEV];
  int          obs_cyc [MAXEV];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] enc_r(int op, int rd, int ra, int rb);
    return {6'(op), 5'(ra), 5'(rb), 5'(rd), 11'd0};
  endfunction

  function automatic logic [31:0] enc_m(int op, int ra, int rb, int imm);
    return {6'(op), 5'(ra), 5'(rb), 16'(imm)};
  endfunction

  // registers 1..31 loaded with index+100 from data words 1..31, then a no-op
  task automatic build_prefix();
    for (int i = 0; i < ID; i++) prog[i] = '0;
    for (int i = 1; i < 32; i++) prog[i-1] = enc_m(5, 0, i, i);
    prog[31] = '0;
    plen = 32;
  endtask

  task automatic add_ins(logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  // sequential reference: one instruction fully done before the next
  task automatic run_model();
    logic [31:0] rf [32];
    logic [31:0] va, vb, imm, r, addr;
    logic [5:0]  op;
    int          a, b, d, dst;
    bit          wr;
    for (int i = 0; i < 32; i++) rf[i] = '0;
    for (int i = 0; i < DD; i++) m_dm[i] = dinit[i];
    exp_n = 0;
    for (int k = 0; k < plen; k++) begin
      op  = prog[k][31:26];
      a   = int'(prog[k][25:21]);
      b   = int'(prog[k][20:16]);
      d   = int'(prog[k][15:11]);
      va  = (a == 0) ? 32'd0 : rf[a];
      vb  = (b == 0) ? 32'd0 : rf[b];
      imm = {{16{prog[k][15]}}, prog[k][15:0]};
      addr = va + imm;
      wr = 1'b0; r = '0; dst = 0;
      case (op)
        6'd1: begin r = va + vb; dst = d; wr = 1'b1; end
        6'd2: begin r = va - vb; dst = d; wr = 1'b1; end
        6'd3: begin r = va & vb; dst = d; wr = 1'b1; end
        6'd4: begin r = va | vb; dst = d; wr = 1'b1; end
        6'd5: begin r = m_dm[addr[DAW-1:0]]; dst = b; wr = 1'b1; end
        6'd6: m_dm[addr[DAW-1:0]] = vb;
        default: ;
      endcase
      if (wr && dst != 0) begin
        rf[dst] = r;
        exp_idx[exp_n] = 5'(dst);
        exp_dat[exp_n] = r;
        exp_cyc[exp_n] = k + 4;
        exp_n++;
      end
    end
  endtask

  task automatic run_dut();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < ID; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = IAW'(i); prog_data = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    for (int i = 0; i < DD; i++) begin
      dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(i); dmem_ld_data = dinit[i];
      @(negedge clk);
    end
    dmem_ld_we = 1'b0;
    // R1: no writeback activity while held in reset
    chk(!wb_valid, "R1", "trace idle in reset", 32'(wb_valid), 32'd0);
    rst_n = 1'b1;
    obs_n = 0;
    for (int c = 1; c <= plen + 6; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c <= 3) chk(!wb_valid, "R1", "no write in first cycles", 32'(wb_valid), 32'd0);
      if (wb_valid && obs_n < MAXEV) begin
        obs_idx[obs_n] = wb_idx;
        obs_dat[obs_n] = wb_data;
        obs_cyc[obs_n] = c;
        obs_n++;
      end
    end
    rst_n = 1'b0;
  endtask

  task automatic compare(string dtag);
    int n;
    chk(obs_n == exp_n, "R10", "write count", 32'(obs_n), 32'(exp_n));
    n = (obs_n < exp_n) ? obs_n : exp_n;
    for (int i = 0; i < n; i++) begin
      chk(obs_idx[i] == exp_idx[i], dtag, "dest index", 32'(obs_idx[i]), 32'(exp_idx[i]));
      chk(obs_dat[i] == exp_dat[i], dtag, "write value", obs_dat[i], exp_dat[i]);
      chk(obs_cyc[i] == exp_cyc[i], "R2", "retire cycle", 32'(obs_cyc[i]), 32'(exp_cyc[i]));
    end
    for (int i = 0; i < DD; i++) begin
      dmem_peek_addr = DAW'(i);
      #1;
      chk(dmem_peek_data == m_dm[i], "R9", "data memory word", dmem_peek_data, m_dm[i]);
    end
  endtask

  task automatic chk_reg(int idx, logic [31:0] expv, string req);
    int f = -1;
    for (int i = 0; i < obs_n; i++) if (int'(obs_idx[i]) == idx) f = i;
    chk(f >= 0 && obs_dat[f] == expv, req, $sformatf("last write of r%0d", idx),
        (f >= 0) ? obs_dat[f] : 32'hDEADBEEF, expv);
  endtask

  task automatic run_case(string dtag);
    run_model();
    run_dut();
    compare(dtag);
  endtask

  task automatic gen_random(int n);
    int prev = 0;
    build_prefix();
    for (int j = 0; j < n; j++) begin
      int r = int'($urandom % 10);
      int a = int'($urandom % 8);
      int b = int'($urandom % 8);
      int d = int'($urandom % 8);
      if (prev != 0) begin
        if (a == prev) a = (a + 1) % 8;
        if (b == prev) b = (b + 1) % 8;
      end
      if (r < 6) begin
        add_ins(enc_r(1 + int'($urandom % 4), d, a, b)); prev = 0;
      end else if (r < 8) begin
        add_ins(enc_m(5, a, b, int'($urandom % 64))); prev = b;
      end else if (r == 8) begin
        add_ins(enc_m(6, a, b, int'($urandom % 64))); prev = 0;
      end else begin
        add_ins('0); prev = 0;
      end
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    dmem_ld_we = 1'b0; dmem_ld_addr = '0; dmem_ld_data = '0;
    dmem_peek_addr = '0;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DD; i++) dinit[i] = (i < 32) ? 32'(i + 100) : 32'(i * 7 + 3);

    // R11 / R4 / R5 / R7: dependent chain on r2
    build_prefix();
    add_ins(enc_r(2, 2, 1, 3));
    add_ins(enc_r(3, 12, 2, 5));
    add_ins(enc_r(4, 13, 6, 2));
    add_ins(enc_r(1, 14, 2, 2));
    add_ins(enc_m(6, 2, 15, 100));
    run_case("R4");
    chk(obs_n > 0 && obs_cyc[0] == 4, "R1", "first retire cycle", 32'(obs_cyc[0]), 32'd4);
    chk_reg(2, 32'hFFFF_FFFE, "R11");
    chk_reg(12, 32'd104, "R4");
    chk_reg(13, 32'hFFFF_FFFE, "R5");
    chk_reg(14, 32'hFFFF_FFFC, "R7");
    dmem_peek_addr = DAW'(34);
    #1;
    chk(dmem_peek_data == 32'd115, "R11", "store at r2+100", dmem_peek_data, 32'd115);

    // R6: two writes in a row to r1, then a reader
    build_prefix();
    add_ins(enc_r(1, 1, 2, 3));
    add_ins(enc_r(1, 1, 1, 4));
    add_ins(enc_r(2, 5, 5, 1));
    run_case("R6");
    chk_reg(5, 32'hFFFF_FF34, "R6");

    // R8: register zero
    build_prefix();
    add_ins(enc_r(1, 0, 1, 2));
    add_ins(enc_r(1, 7, 0, 0));
    add_ins(enc_r(4, 8, 0, 3));
    run_case("R8");
    chk_reg(7, 32'd0, "R8");
    chk_reg(8, 32'd103, "R8");
    begin
      int z = 0;
      for (int i = 0; i < obs_n; i++) if (obs_idx[i] == 5'd0) z++;
      chk(z == 0, "R8", "writes reported to r0", 32'(z), 32'd0);
    end

    // R9 / R10: forwarded store data, load back, load forwarded two slots on
    build_prefix();
    add_ins(enc_r(1, 4, 1, 1));
    add_ins(enc_m(6, 0, 4, 5));
    add_ins(enc_m(5, 0, 9, 5));
    add_ins('0);
    add_ins(enc_r(1, 10, 9, 0));
    run_case("R9");
    chk_reg(10, 32'd202, "R9");
    dmem_peek_addr = DAW'(5);
    #1;
    chk(dmem_peek_data == 32'd202, "R9", "stored word", dmem_peek_data, 32'd202);

    // random programs over a narrow register set
    for (int t = 0; t < 6; t++) begin
      gen_random(60);
      run_case("R3");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule